// File: doc/BRIEF.md
# Overlay Source Priority Selector

This block chooses, for every valid pixel, which of three candidate colours reaches the display: the main video picture, a flat border colour drawn around or over the picture, or an on-screen-display RGB overlay. The border and the overlay each carry a per-pixel active flag and each has its own enable. A run-time setting decides which of the two overlays wins where both are active. Video is the fallback and appears only where no enabled overlay is active.

Alongside the chosen colour, the block reports which source was chosen as a 2-bit code. It also raises a flag that tells a downstream sharpening stage to hold back its peaking around edges between video and border. Two picture-adjust requests are passed on only for video pixels: the black-level stretch and the alternate contrast/brightness/matrix setting. Every output is registered and advances only on valid pixels.

Top module: `ovl_src_select`

## Requirements
- R1: The source code `out_src` is 2'b00 for video, 2'b01 for border and 2'b10 for overlay. The value 2'b11 never appears.
- R2: When exactly one of the two overlays is both enabled and active on a pixel, that overlay is selected. When neither is, video is selected.
- R3: When both overlays are enabled and active on a pixel, the overlay is selected if `cfg_osd_first` is 1 and the border is selected if it is 0.
- R4: A disabled overlay is never selected, whatever its active flag says.
- R5: `out_rgb` carries the colour of the source named by `out_src` for the same pixel.
- R6: Outputs are registered. They change one clock after a cycle with `pix_vld` high and hold their values through cycles with `pix_vld` low.
- R7: With `cfg_supp_en` high, a change of selected source from video to border, or from border to video, drives `pk_supp` high for two valid pixels: the first pixel of the new source and the one after it. Changes that involve the overlay do not set the flag. With `cfg_supp_en` low, the flag stays low.
- R8: `ble_act` follows `cfg_ble_en` and `side_act` follows `cfg_side_sel`, but only for pixels where video is selected. Both are 0 for border and overlay pixels.
- R9: After reset, `out_rgb` is 0, `out_src` is video, and `pk_supp`, `ble_act` and `side_act` are 0.
- R10: Configuration inputs are sampled only on valid pixels, so a change between pixels first shows at the next valid pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_vld | input | 1 | Pixel valid strobe |
| vid_rgb | input | 3*CW | Main video colour |
| frm_rgb | input | 3*CW | Border colour |
| osd_rgb | input | 3*CW | Overlay colour |
| frm_act | input | 1 | Border active on this pixel |
| osd_act | input | 1 | Overlay active on this pixel |
| cfg_frm_en | input | 1 | Border enable |
| cfg_osd_en | input | 1 | Overlay enable |
| cfg_osd_first | input | 1 | 1: overlay beats border, 0: border beats overlay |
| cfg_supp_en | input | 1 | Enable peaking suppression at video/border edges |
| cfg_ble_en | input | 1 | Black-level stretch request |
| cfg_side_sel | input | 1 | Alternate picture-setting request |
| out_rgb | output | 3*CW | Selected colour |
| out_src | output | 2 | Selected source code |
| pk_supp | output | 1 | Peaking-suppress flag |
| ble_act | output | 1 | Black-level stretch applied to this pixel |
| side_act | output | 1 | Alternate setting applied to this pixel |

## Verification
The selector is driven with each overlay active alone, with both active under each priority setting, and with active flags set while the matching enables are off. These cases separate the priority order from the enable gating. Pixel runs that cross video/border edges are compared with runs that cross video/overlay edges, with suppression both on and off, to show the flag's two-pixel width and that it responds only to the border edge. Idle cycles with changed inputs between valid pixels show that the outputs hold and that configuration is taken only on valid pixels.

// File: rtl/ovl_src_select.sv
module ovl_src_select #(
  parameter int CW = 8,
  localparam int PW = 3 * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_vld,
  input  logic [PW-1:0] vid_rgb,
  input  logic [PW-1:0] frm_rgb,
  input  logic [PW-1:0] osd_rgb,
  input  logic          frm_act,
  input  logic          osd_act,
  input  logic          cfg_frm_en,
  input  logic          cfg_osd_en,
  input  logic          cfg_osd_first,
  input  logic          cfg_supp_en,
  input  logic          cfg_ble_en,
  input  logic          cfg_side_sel,
  output logic [PW-1:0] out_rgb,
  output logic [1:0]    out_src,
  output logic          pk_supp,
  output logic          ble_act,
  output logic          side_act
);

  localparam logic [1:0] SRC_VID = 2'b00;
  localparam logic [1:0] SRC_FRM = 2'b01;
  localparam logic [1:0] SRC_OSD = 2'b10;

  logic          use_frm, use_osd;
  logic [1:0]    nxt_src;
  logic [PW-1:0] nxt_rgb;
  logic          edge_now, edge_d;

  assign use_frm = cfg_frm_en & frm_act;
  assign use_osd = cfg_osd_en & osd_act;

  always_comb begin
    if (use_frm && use_osd) nxt_src = cfg_osd_first ? SRC_OSD : SRC_FRM;
    else if (use_osd)       nxt_src = SRC_OSD;
    else if (use_frm)       nxt_src = SRC_FRM;
    else                    nxt_src = SRC_VID;
  end

  always_comb begin
    unique case (nxt_src)
      SRC_FRM: nxt_rgb = frm_rgb;
      SRC_OSD: nxt_rgb = osd_rgb;
      default: nxt_rgb = vid_rgb;
    endcase
  end

  assign edge_now = cfg_supp_en &
                    (((out_src == SRC_VID) && (nxt_src == SRC_FRM)) ||
                     ((out_src == SRC_FRM) && (nxt_src == SRC_VID)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_rgb  <= '0;
      out_src  <= SRC_VID;
      pk_supp  <= 1'b0;
      edge_d   <= 1'b0;
      ble_act  <= 1'b0;
      side_act <= 1'b0;
    end else if (pix_vld) begin
      out_rgb  <= nxt_rgb;
      out_src  <= nxt_src;
      edge_d   <= edge_now;
      pk_supp  <= edge_now | (edge_d & cfg_supp_en);
      ble_act  <= cfg_ble_en & (nxt_src == SRC_VID);
      side_act <= cfg_side_sel & (nxt_src == SRC_VID);
    end
  end

  a_r1_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_src != 2'b11);

  a_r4_disabled_never: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && !cfg_osd_en && !cfg_frm_en) |=> out_src == SRC_VID);

  a_r3_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && use_frm && use_osd) |=>
      out_src == ($past(cfg_osd_first) ? SRC_OSD : SRC_FRM));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> ($stable(out_rgb) && $stable(out_src) && $stable(pk_supp)));

  a_r7_supp_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pk_supp) |-> (out_src != $past(out_src)));

  a_r8_video_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ble_act || side_act) |-> out_src == SRC_VID);

endmodule

// File: tb/ovl_src_select_bench.sv
module ovl_src_select_bench;
  localparam int CW = 8;
  localparam int PW = 3 * CW;
  localparam logic [PW-1:0] VC = 24'h102030;
  localparam logic [PW-1:0] FC = 24'hA0B0C0;
  localparam logic [PW-1:0] OC = 24'h5A6B7C;

  logic clk = 0, rst_n = 0, pix_vld = 0;
  logic [PW-1:0] vid_rgb = VC, frm_rgb = FC, osd_rgb = OC;
  logic frm_act = 0, osd_act = 0, cfg_frm_en = 0, cfg_osd_en = 0;
  logic cfg_osd_first = 0, cfg_supp_en = 0, cfg_ble_en = 0, cfg_side_sel = 0;
  logic [PW-1:0] out_rgb;
  logic [1:0] out_src;
  logic pk_supp, ble_act, side_act;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ovl_src_select #(.CW(CW)) u_ovl_src_select (.*);

  task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pix(input logic f, input logic o);
    @(negedge clk);
    frm_act = f; osd_act = o; pix_vld = 1;
    @(posedge clk); #1;
    pix_vld = 0;
  endtask

  task automatic t_reset();
    chk("R9 rgb", out_rgb, 0);
    chk("R9 src", {22'd0, out_src}, 0);
    chk("R9 flags", {21'd0, pk_supp, ble_act, side_act}, 0);
  endtask

  task automatic t_single();
    cfg_frm_en = 1; cfg_osd_en = 1; cfg_osd_first = 1;
    pix(0, 0); chk("R2 none src", {22'd0, out_src}, 0); chk("R5 vid rgb", out_rgb, VC);
    pix(1, 0); chk("R2 frm src", {22'd0, out_src}, 1); chk("R5 frm rgb", out_rgb, FC);
    pix(0, 1); chk("R1 osd src", {22'd0, out_src}, 2); chk("R5 osd rgb", out_rgb, OC);
  endtask

  task automatic t_priority();
    cfg_frm_en = 1; cfg_osd_en = 1;
    cfg_osd_first = 1; pix(1, 1); chk("R3 osd first", {22'd0, out_src}, 2);
    cfg_osd_first = 0; pix(1, 1); chk("R3 frm first", {22'd0, out_src}, 1);
    chk("R3 frm first rgb", out_rgb, FC);
  endtask

  task automatic t_disable();
    cfg_frm_en = 0; cfg_osd_en = 1; cfg_osd_first = 0;
    pix(1, 1); chk("R4 frm off", {22'd0, out_src}, 2);
    cfg_osd_en = 0; pix(1, 1); chk("R4 both off", {22'd0, out_src}, 0);
    chk("R4 both off rgb", out_rgb, VC);
    cfg_frm_en = 1; pix(1, 1); chk("R4 osd off", {22'd0, out_src}, 1);
  endtask

  task automatic t_hold();
    cfg_frm_en = 1; cfg_osd_en = 1;
    pix(1, 0);
    @(negedge clk); frm_act = 0; osd_act = 1; cfg_frm_en = 0;
    @(posedge clk); #1;
    chk("R6 hold src", {22'd0, out_src}, 1);
    chk("R6 hold rgb", out_rgb, FC);
    pix(1, 0); chk("R10 cfg at next pixel", {22'd0, out_src}, 0);
    cfg_frm_en = 1;
  endtask

  task automatic t_supp();
    logic [6:0] fr = 7'b0011100;
    logic [6:0] ex = 7'b0011011;
    cfg_frm_en = 1; cfg_osd_en = 1; cfg_supp_en = 1;
    pix(0, 0); pix(0, 0);
    for (int i = 0; i < 7; i++) begin
      pix(fr[6-i], 0);
      chk($sformatf("R7 vid/frm px%0d", i), {23'd0, pk_supp}, {23'd0, ex[6-i]});
    end
    pix(0, 1); chk("R7 vid->osd", {23'd0, pk_supp}, 0);
    pix(0, 0); chk("R7 osd->vid", {23'd0, pk_supp}, 0);
    cfg_supp_en = 0;
    pix(1, 0); chk("R7 off a", {23'd0, pk_supp}, 0);
    pix(0, 0); chk("R7 off b", {23'd0, pk_supp}, 0);
  endtask

  task automatic t_gate();
    cfg_frm_en = 1; cfg_osd_en = 1; cfg_ble_en = 1; cfg_side_sel = 1;
    pix(0, 0); chk("R8 vid", {22'd0, ble_act, side_act}, 2'b11);
    pix(1, 0); chk("R8 frm", {22'd0, ble_act, side_act}, 0);
    pix(0, 1); chk("R8 osd", {22'd0, ble_act, side_act}, 0);
    cfg_side_sel = 0;
    pix(0, 0); chk("R8 vid side off", {22'd0, ble_act, side_act}, 2'b10);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1;
    t_single();
    t_priority();
    t_disable();
    t_hold();
    t_supp();
    t_gate();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule